// File: doc/BRIEF.md
# Transport FIFO Occupancy and Progress Watchdog

This block sits next to the receive and transmit buffers of a serial storage transport layer and watches them. It never touches the stored words. On the receive side it turns the free-entry count of the buffer into a nearly-full warning. It also runs a progress watchdog that fires when a frame is awaited but the link side has stopped writing words into the buffer.

On the transmit side a second watchdog arms once the transport side has queued a complete frame. It fires when the link side stops reading that frame out. Each watchdog keeps its own idle counter, and each timeout flag holds until software-side control logic pulses the matching clear input. Thresholds, counter widths and the buffer depth are parameters. The defaults are a 32-entry buffer, a nearly-full threshold of 20 and 999-cycle idle limits held in 10-bit counters.

Top module: `fifo_guard`

## Requirements
- R1: A synchronous active-high reset clears both idle counters and both timeout flags. `rxtimeout` and `txtimeout` read 0 after any clock edge at which `rst` is 1.
- R2: `nearfull` is combinational on `rx_free`. It is 1 exactly when `rx_free - 1 < 20` in signed arithmetic, that is for `rx_free` from 0 to 20. It is 0 for `rx_free` from 21 to 32.
- R3: With `rx_expect` high and `rx_wr` low at 999 consecutive clock edges, `rxtimeout` becomes 1 after the 999th such edge and not earlier.
- R4: A receive write (`rx_wr` = 1) at a clock edge restarts the receive idle count. A further 999 idle edges are then needed before `rxtimeout` rises.
- R5: While `rx_expect` is low the receive idle count is held at zero, so an idle run interrupted by a low `rx_expect` starts over.
- R6: With `tx_queued` high and `tx_rd` low at 999 consecutive clock edges, `txtimeout` becomes 1 after the 999th such edge and not earlier.
- R7: A transmit read (`tx_rd` = 1) restarts the transmit idle count, and the count is held at zero while `tx_queued` is low.
- R8: Once set, each timeout flag stays at 1 whatever its arm and progress inputs do, until its clear input or reset.
- R9: A clear pulse (`rx_clr` or `tx_clr`) at a clock edge sets that flag to 0 after the edge and restarts its idle count. It wins over a timeout reached at the same edge.
- R10: The two watchdogs are independent. The inputs of one channel never change the flag of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_wr | input | 1 | Link side wrote a word into the receive buffer this cycle |
| tx_rd | input | 1 | Link side read a word out of the transmit buffer this cycle |
| rx_free | input | 6 | Number of unused receive buffer entries (0 to 32) |
| rx_expect | input | 1 | Transport side is waiting for an incoming frame |
| tx_queued | input | 1 | Transport side has finished queuing an outgoing frame |
| rx_clr | input | 1 | Clear pulse for the receive timeout |
| tx_clr | input | 1 | Clear pulse for the transmit timeout |
| nearfull | output | 1 | Receive buffer nearly full |
| rxtimeout | output | 1 | Receive progress timeout, sticky |
| txtimeout | output | 1 | Transmit progress timeout, sticky |

## Verification
The bench targets the exact firing edge of each watchdog by running 998 idle cycles and then one more. A counter that is off by one would fire a cycle early or late. It interrupts idle runs with a single write or read, or with a one-cycle drop of the arm flag. A design that only paused the count there would then fire long before a fresh 999-cycle run. A clear is placed on the very edge where a timeout would be reached, which catches set-over-clear priority. The bench sweeps `rx_free` across 0, 20 and 21, where a wrapped or unsigned "minus one" comparison or an off-by-one threshold gives the wrong `nearfull`.

// File: rtl/fifo_guard_pkg.sv
package fifo_guard_pkg;
   localparam int unsigned CH_RX  = 0;
   localparam int unsigned CH_TX  = 1;
   localparam int unsigned NUM_CH = 2;

   // bits needed to hold any occupancy value from 0 to depth inclusive
   function automatic int unsigned occ_width(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/fg_idle_watch.sv
// Idle-progress watchdog: counts armed cycles with no progress and raises a
// sticky flag on the LIMIT-th consecutive one.
module fg_idle_watch #(
   parameter int unsigned TO_W  = 10,
   parameter int unsigned LIMIT = 999
) (
   input  logic clk,
   input  logic rst,
   input  logic arm,
   input  logic progress,
   input  logic clr,
   output logic timeout
);
   localparam logic [TO_W-1:0] LIM_V  = TO_W'(LIMIT);
   localparam logic [TO_W-1:0] LAST_V = TO_W'(LIMIT - 1);

   generate
      if (LIMIT < 1 || LIMIT >= (64'd1 << TO_W)) begin : g_bad_limit
         $error("fg_idle_watch: LIMIT must fit in TO_W bits and be nonzero");
      end
   endgenerate

   logic [TO_W-1:0] idle_cnt;
   logic            idle;

   assign idle = arm & ~progress;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         idle_cnt <= '0;
      end else if (!idle) begin
         idle_cnt <= '0;
      end else if (idle_cnt != LIM_V) begin
         idle_cnt <= idle_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         timeout <= 1'b0;
      end else if (idle && idle_cnt == LAST_V) begin
         timeout <= 1'b1;
      end
   end
endmodule

// File: rtl/fg_near_cmp.sv
// Nearly-full decision on the free-entry count: (free - 1) < NEAR_LIM,
// with an empty free count (buffer full) also counted as nearly full.
module fg_near_cmp #(
   parameter int unsigned DEPTH    = 32,
   parameter int unsigned FREE_W   = 6,
   parameter int unsigned NEAR_LIM = 20
) (
   input  logic [FREE_W-1:0] free_cnt,
   output logic              near
);
   localparam logic [FREE_W-1:0] TH_V = FREE_W'(NEAR_LIM);

   generate
      if (NEAR_LIM >= DEPTH) begin : g_bad_lim
         $error("fg_near_cmp: NEAR_LIM must be below DEPTH");
      end
      if ((64'd1 << FREE_W) <= DEPTH) begin : g_bad_w
         $error("fg_near_cmp: FREE_W too narrow for DEPTH");
      end
   endgenerate

   // free - 1 < NEAR_LIM  <=>  free <= NEAR_LIM (no wrap at free == 0)
   assign near = (free_cnt <= TH_V);
endmodule

// File: rtl/fifo_guard.sv
module fifo_guard #(
   parameter int unsigned DEPTH    = 32,
   parameter int unsigned FREE_W   = fifo_guard_pkg::occ_width(32),
   parameter int unsigned NEAR_LIM = 20,
   parameter int unsigned TO_W     = 10,
   parameter int unsigned RX_LIMIT = 999,
   parameter int unsigned TX_LIMIT = 999
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rx_wr,
   input  logic              tx_rd,
   input  logic [FREE_W-1:0] rx_free,
   input  logic              rx_expect,
   input  logic              tx_queued,
   input  logic              rx_clr,
   input  logic              tx_clr,
   output logic              nearfull,
   output logic              rxtimeout,
   output logic              txtimeout
);
   import fifo_guard_pkg::*;

   generate
      if (FREE_W < occ_width(DEPTH)) begin : g_bad_free_w
         $error("fifo_guard: FREE_W cannot hold DEPTH");
      end
   endgenerate

   logic [NUM_CH-1:0] arm_v, prog_v, clr_v, to_v;

   assign arm_v[CH_RX]  = rx_expect;
   assign arm_v[CH_TX]  = tx_queued;
   assign prog_v[CH_RX] = rx_wr;
   assign prog_v[CH_TX] = tx_rd;
   assign clr_v[CH_RX]  = rx_clr;
   assign clr_v[CH_TX]  = tx_clr;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      localparam int unsigned LIM = (g == CH_RX) ? RX_LIMIT : TX_LIMIT;
      fg_idle_watch #(
         .TO_W  (TO_W),
         .LIMIT (LIM)
      ) u_watch (
         .clk      (clk),
         .rst      (rst),
         .arm      (arm_v[g]),
         .progress (prog_v[g]),
         .clr      (clr_v[g]),
         .timeout  (to_v[g])
      );
   end

   fg_near_cmp #(
      .DEPTH    (DEPTH),
      .FREE_W   (FREE_W),
      .NEAR_LIM (NEAR_LIM)
   ) u_near (
      .free_cnt (rx_free),
      .near     (nearfull)
   );

   assign rxtimeout = to_v[CH_RX];
   assign txtimeout = to_v[CH_TX];
endmodule

// File: rtl/fifo_guard_chk.sv
module fifo_guard_chk #(
   parameter int unsigned FREE_W   = 6,
   parameter int unsigned NEAR_LIM = 20,
   parameter int unsigned TO_W     = 10,
   parameter int unsigned RX_LIMIT = 999,
   parameter int unsigned TX_LIMIT = 999
) (
   input logic              clk,
   input logic              rst,
   input logic              rx_wr,
   input logic              tx_rd,
   input logic [FREE_W-1:0] rx_free,
   input logic              rx_expect,
   input logic              tx_queued,
   input logic              rx_clr,
   input logic              tx_clr,
   input logic              nearfull,
   input logic              rxtimeout,
   input logic              txtimeout
);
   logic [TO_W:0] rx_idle, tx_idle;

   always_ff @(posedge clk) begin
      if (rst || rx_clr || !rx_expect || rx_wr) rx_idle <= '0;
      else if (rx_idle != (TO_W+1)'(RX_LIMIT)) rx_idle <= rx_idle + 1'b1;
      if (rst || tx_clr || !tx_queued || tx_rd) tx_idle <= '0;
      else if (tx_idle != (TO_W+1)'(TX_LIMIT)) tx_idle <= tx_idle + 1'b1;
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (!rxtimeout && !txtimeout));

   assert_nearfull_R2: assert property (@(posedge clk) disable iff (rst)
      nearfull == ((int'(rx_free) - 1) < int'(NEAR_LIM)));

   assert_rx_rise_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(rxtimeout) |-> (rx_idle == (TO_W+1)'(RX_LIMIT)));

   assert_rx_restart_R4: assert property (@(posedge clk) disable iff (rst)
      (rx_wr || !rx_expect) |=> !$rose(rxtimeout));

   assert_tx_rise_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(txtimeout) |-> (tx_idle == (TO_W+1)'(TX_LIMIT)));

   assert_tx_restart_R7: assert property (@(posedge clk) disable iff (rst)
      (tx_rd || !tx_queued) |=> !$rose(txtimeout));

   assert_rx_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      (rxtimeout && !rx_clr) |=> rxtimeout);

   assert_tx_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      (txtimeout && !tx_clr) |=> txtimeout);

   assert_rx_clear_R9: assert property (@(posedge clk) disable iff (rst)
      rx_clr |=> !rxtimeout);

   assert_tx_clear_R9: assert property (@(posedge clk) disable iff (rst)
      tx_clr |=> !txtimeout);
endmodule

bind fifo_guard fifo_guard_chk #(
   .FREE_W   (FREE_W),
   .NEAR_LIM (NEAR_LIM),
   .TO_W     (TO_W),
   .RX_LIMIT (RX_LIMIT),
   .TX_LIMIT (TX_LIMIT)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .rx_wr     (rx_wr),
   .tx_rd     (tx_rd),
   .rx_free   (rx_free),
   .rx_expect (rx_expect),
   .tx_queued (tx_queued),
   .rx_clr    (rx_clr),
   .tx_clr    (tx_clr),
   .nearfull  (nearfull),
   .rxtimeout (rxtimeout),
   .txtimeout (txtimeout)
);

// File: tb/tb_fifo_guard.sv
`timescale 1ns/1ps
module tb_fifo_guard;
   localparam int LIMIT = 999;
   localparam int NEAR  = 20;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       rx_wr = 1'b0, tx_rd = 1'b0;
   logic [5:0] rx_free = 6'd32;
   logic       rx_expect = 1'b0, tx_queued = 1'b0;
   logic       rx_clr = 1'b0, tx_clr = 1'b0;
   logic       nearfull, rxtimeout, txtimeout;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // model state, index 0 = receive, 1 = transmit
   int m_cnt [2];
   bit m_flag[2];

   always #10 clk = ~clk;

   fifo_guard dut (
      .clk(clk), .rst(rst), .rx_wr(rx_wr), .tx_rd(tx_rd), .rx_free(rx_free),
      .rx_expect(rx_expect), .tx_queued(tx_queued), .rx_clr(rx_clr),
      .tx_clr(tx_clr), .nearfull(nearfull), .rxtimeout(rxtimeout),
      .txtimeout(txtimeout));

   function automatic bit exp_near(input int free);
      return (free - 1) < NEAR;
   endfunction

   task automatic model_ch(input int c, input bit arm, input bit prog, input bit clr);
      if (rst || clr) begin
         m_cnt[c] = 0; m_flag[c] = 1'b0;
      end else if (!arm || prog) begin
         m_cnt[c] = 0;
      end else if (m_cnt[c] < LIMIT) begin
         m_cnt[c] = m_cnt[c] + 1;
         if (m_cnt[c] == LIMIT) m_flag[c] = 1'b1;
      end
   endtask

   task automatic check(input string tag, input string what, input bit act, input bit exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic tick(input string tag);
      @(posedge clk);
      model_ch(0, rx_expect, rx_wr, rx_clr);
      model_ch(1, tx_queued, tx_rd, tx_clr);
      @(negedge clk);
      check(tag, "rxtimeout", rxtimeout, m_flag[0]);
      check(tag, "txtimeout", txtimeout, m_flag[1]);
      check(tag, "nearfull",  nearfull,  exp_near(int'(rx_free)));
   endtask

   task automatic run(input int n, input string tag);
      for (int i = 0; i < n; i++) tick(tag);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      m_cnt[0] = 0; m_cnt[1] = 0; m_flag[0] = 0; m_flag[1] = 0;
      rx_expect = 1'b1; tx_queued = 1'b1;
      run(3, "R1 reset");
      rst = 1'b0; rx_expect = 1'b0; tx_queued = 1'b0;
      tick("R1 after reset");

      // R2: sweep free count, including 0, 20 and 21
      for (int f = 0; f <= 32; f++) begin
         rx_free = 6'(f);
         #1 check("R2 sweep", "nearfull", nearfull, exp_near(f));
         tick("R2");
      end

      // R3: exact firing edge
      rx_expect = 1'b1;
      run(998, "R3 before limit");
      check("R3 not yet", "rxtimeout", rxtimeout, 1'b0);
      tick("R3 at limit");
      check("R3 fired", "rxtimeout", rxtimeout, 1'b1);
      check("R10 tx quiet", "txtimeout", txtimeout, 1'b0);

      // R9: clear, then R4 write restarts
      rx_clr = 1'b1; tick("R9 clear"); rx_clr = 1'b0;
      check("R9 cleared", "rxtimeout", rxtimeout, 1'b0);
      run(500, "R4 pre");
      rx_wr = 1'b1; tick("R4 write"); rx_wr = 1'b0;
      run(998, "R4 restart");
      check("R4 not yet", "rxtimeout", rxtimeout, 1'b0);
      tick("R4 limit");
      check("R4 fired", "rxtimeout", rxtimeout, 1'b1);
      rx_clr = 1'b1; tick("R9"); rx_clr = 1'b0;

      // R5: expect drop restarts
      run(600, "R5 pre");
      rx_expect = 1'b0; tick("R5 drop"); rx_expect = 1'b1;
      run(998, "R5 restart");
      check("R5 not yet", "rxtimeout", rxtimeout, 1'b0);
      tick("R5 limit");
      check("R5 fired", "rxtimeout", rxtimeout, 1'b1);

      // R8: sticky through progress and disarm
      rx_wr = 1'b1; run(5, "R8 writes"); rx_wr = 1'b0;
      rx_expect = 1'b0; run(20, "R8 disarm");
      check("R8 sticky", "rxtimeout", rxtimeout, 1'b1);

      // R9: clear wins on the limit edge
      rx_clr = 1'b1; tick("R9"); rx_clr = 1'b0;
      rx_expect = 1'b1;
      run(998, "R9 pre");
      rx_clr = 1'b1; tick("R9 clear on limit"); rx_clr = 1'b0;
      check("R9 priority", "rxtimeout", rxtimeout, 1'b0);
      rx_expect = 1'b0; tick("R9");

      // R6/R7/R10: transmit channel while receive makes progress
      tx_queued = 1'b1; rx_expect = 1'b1; rx_wr = 1'b1;
      run(998, "R6 before limit");
      check("R6 not yet", "txtimeout", txtimeout, 1'b0);
      tick("R6 limit");
      check("R6 fired", "txtimeout", txtimeout, 1'b1);
      check("R10 rx quiet", "rxtimeout", rxtimeout, 1'b0);
      tx_clr = 1'b1; tick("R9 tx clear"); tx_clr = 1'b0;
      run(700, "R7 pre");
      tx_rd = 1'b1; tick("R7 read"); tx_rd = 1'b0;
      run(400, "R7 pre2");
      tx_queued = 1'b0; tick("R7 unqueued"); tx_queued = 1'b1;
      run(998, "R7 restart");
      check("R7 not yet", "txtimeout", txtimeout, 1'b0);
      tick("R7 limit");
      check("R7 fired", "txtimeout", txtimeout, 1'b1);
      tx_queued = 1'b0; tx_rd = 1'b1; run(10, "R8 tx sticky"); tx_rd = 1'b0;
      check("R8 tx sticky", "txtimeout", txtimeout, 1'b1);
      rx_wr = 1'b0;

      // R1: mid-run reset
      rst = 1'b1; tick("R1 mid reset"); rst = 1'b0;
      check("R1 mid", "txtimeout", txtimeout, 1'b0);

      // constrained random phase, fixed seed
      void'($urandom(32'h5eed_1234));
      for (int blk = 0; blk < 12; blk++) begin
         int pdiv;
         pdiv = (blk % 3 == 0) ? 1500 : ((blk % 3 == 1) ? 400 : 40);
         for (int i = 0; i < 1500; i++) begin
            rx_wr     = ($urandom % pdiv) == 0;
            tx_rd     = ($urandom % pdiv) == 0;
            rx_expect = ($urandom % 500) != 0;
            tx_queued = ($urandom % 700) != 0;
            rx_clr    = ($urandom % 2500) == 0;
            tx_clr    = ($urandom % 2500) == 0;
            rx_free   = 6'($urandom % 33);
            tick("RND R2-R10 mix");
         end
      end
      rx_wr = 0; tx_rd = 0; rx_clr = 0; tx_clr = 0;
      tick("RND end");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule